// File: doc/BRIEF.md
# Virtualized Timer Counter Read Unit

This block keeps a free-running interval time counter together with a host-programmed offset register. It decides what a read of the counter returns when the read comes from guest code running under virtualization. Host software may load either register at any time. Each read request is resolved against a small decision table built from a static optimization enable, a host timer-secure bit, a virtual timer-secure bit and the guest's virtual privilege level.

A guest read has one of three outcomes. It may return the raw counter. It may return the counter plus the offset, so the host can shift the time the guest sees without taking a trap. Otherwise it reports a trap, which is either a virtualization intercept or a privileged-register fault. One table combination has no defined meaning, and the block reports it with its own trap code rather than guessing. When a second static enable is set, intercepts also carry a cause code that tells the handler which table row produced them.

All results are registered. The result appears one clock after the request and is marked by a one-cycle valid pulse.

Top module: `vtimer_read_unit`

## Requirements
- R1: After reset the counter holds 0. It then advances by one every clock and wraps from all ones to zero.
- R2: A host load of the counter or the offset takes effect on the next clock. A read in the same cycle as the load sees the value from before the load.
- R3: When `vm_mode` is 0, a read returns the raw counter with `trap_kind` = 2'b00, whatever the other inputs are.
- R4: With `cfg_opt_en` = 0 and both secure bits 0, a guest read returns the raw counter with no trap.
- R5: With `cfg_opt_en` = 1 and both secure bits 0, a guest read returns counter plus offset, taken modulo 2^64, with no trap.
- R6: With `host_sec` = 1 and `virt_sec` = 0, a guest read gives an intercept (`trap_kind` = 2'b01), whatever the value of `cfg_opt_en`.
- R7: With both secure bits 1, a nonzero `virt_pl` gives a privileged-register fault (`trap_kind` = 2'b10), and `virt_pl` = 0 gives an intercept (2'b01).
- R8: With `cfg_opt_en` = 1, `host_sec` = 0 and `virt_sec` = 1, a nonzero `virt_pl` gives a fault (2'b10), and `virt_pl` = 0 returns counter plus offset with no trap.
- R9: With `cfg_opt_en` = 0, `host_sec` = 0 and `virt_sec` = 1, the read is flagged as undefined with `trap_kind` = 2'b11.
- R10: An intercept raises `cause_valid` only when `cfg_cause_en` = 1. The cause code is 4'h1 for the host-secure-only row and 4'h2 for the both-secure row at level 0. In every other case `cause_valid` = 0 and `cause_code` = 0.
- R11: `rd_valid` pulses for exactly one cycle, one clock after each request. Whenever `rd_valid` is 0, all result outputs are 0. Whenever `trap_kind` is nonzero, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_opt_en | input | 1 | Static enable for offset-adjusted guest reads |
| cfg_cause_en | input | 1 | Static enable for intercept cause reporting |
| host_cnt_we | input | 1 | Host load strobe for the counter |
| host_cnt_wdata | input | 64 | Value loaded into the counter |
| host_ofs_we | input | 1 | Host load strobe for the offset |
| host_ofs_wdata | input | 64 | Value loaded into the offset |
| rd_req | input | 1 | Read request |
| vm_mode | input | 1 | Requester runs under virtualization |
| host_sec | input | 1 | Host timer-secure bit |
| virt_sec | input | 1 | Virtual timer-secure bit |
| virt_pl | input | 2 | Virtual privilege level, 0 is most privileged |
| rd_data | output | 64 | Read result |
| rd_valid | output | 1 | One-cycle result strobe |
| trap_kind | output | 2 | 00 none, 01 intercept, 10 privileged fault, 11 undefined |
| cause_valid | output | 1 | A cause code is being presented |
| cause_code | output | 4 | Intercept cause |

## Verification
The assertions assume that `cfg_opt_en` and `cfg_cause_en` never change in the cycle of a read, since they relate a result to the configuration sampled one clock earlier. They also assume `rd_req` is low while reset is applied. The bench changes the configuration only in idle cycles with no request, holds every strobe low during reset, and draws all other inputs, including simultaneous host loads and reads, freely from a seeded random source.

// File: rtl/vtr_pkg.sv
package vtr_pkg;
    typedef enum logic [1:0] {
        TRAP_NONE      = 2'b00,
        TRAP_INTERCEPT = 2'b01,
        TRAP_PRIV      = 2'b10,
        TRAP_UNDEF     = 2'b11
    } trap_e;

    typedef enum logic [1:0] {
        ACT_RAW  = 2'b00,
        ACT_SUM  = 2'b01,
        ACT_TRAP = 2'b10
    } act_e;

    localparam int CAUSE_W = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_NONE     = 4'h0;
    localparam logic [CAUSE_W-1:0] CAUSE_HOST_SEC = 4'h1;
    localparam logic [CAUSE_W-1:0] CAUSE_BOTH_SEC = 4'h2;
endpackage

// File: rtl/vtr_time_base.sv
module vtr_time_base #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             ofs_we,
    input  logic [CNT_W-1:0] ofs_wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] ofs_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ofs;
    } base_t;

    base_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_we ? cnt_wdata : st_q.cnt + ONE;
        if (ofs_we) begin
            st_d.ofs = ofs_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign ofs_o = st_q.ofs;
endmodule

// File: rtl/vtr_decide.sv
module vtr_decide
    import vtr_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  logic               opt_en,
    input  logic               vm,
    input  logic               hsec,
    input  logic               vsec,
    input  logic [PL_W-1:0]    pl,
    output act_e               act,
    output trap_e              kind,
    output logic [CAUSE_W-1:0] cause
);
    logic pl_nz;
    assign pl_nz = |pl;

    always_comb begin
        act   = ACT_RAW;
        kind  = TRAP_NONE;
        cause = CAUSE_NONE;
        if (vm) begin
            unique case ({hsec, vsec})
                2'b00: act = opt_en ? ACT_SUM : ACT_RAW;
                2'b01: begin
                    if (!opt_en) begin
                        act  = ACT_TRAP;
                        kind = TRAP_UNDEF;
                    end else if (pl_nz) begin
                        act  = ACT_TRAP;
                        kind = TRAP_PRIV;
                    end else begin
                        act  = ACT_SUM;
                    end
                end
                2'b10: begin
                    act   = ACT_TRAP;
                    kind  = TRAP_INTERCEPT;
                    cause = CAUSE_HOST_SEC;
                end
                default: begin
                    act = ACT_TRAP;
                    if (pl_nz) begin
                        kind = TRAP_PRIV;
                    end else begin
                        kind  = TRAP_INTERCEPT;
                        cause = CAUSE_BOTH_SEC;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/vtimer_read_unit.sv
module vtimer_read_unit
    import vtr_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int PL_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_opt_en,
    input  logic               cfg_cause_en,
    input  logic               host_cnt_we,
    input  logic [CNT_W-1:0]   host_cnt_wdata,
    input  logic               host_ofs_we,
    input  logic [CNT_W-1:0]   host_ofs_wdata,
    input  logic               rd_req,
    input  logic               vm_mode,
    input  logic               host_sec,
    input  logic               virt_sec,
    input  logic [PL_W-1:0]    virt_pl,
    output logic [CNT_W-1:0]   rd_data,
    output logic               rd_valid,
    output logic [1:0]         trap_kind,
    output logic               cause_valid,
    output logic [CAUSE_W-1:0] cause_code
);
    typedef struct packed {
        logic               valid;
        logic [CNT_W-1:0]   data;
        trap_e              kind;
        logic               cvld;
        logic [CAUSE_W-1:0] cause;
    } res_t;

    logic [CNT_W-1:0]   cnt_now;
    logic [CNT_W-1:0]   ofs_now;
    act_e               dec_act;
    trap_e              dec_kind;
    logic [CAUSE_W-1:0] dec_cause;
    res_t               res_d, res_q;

    vtr_time_base #(.CNT_W(CNT_W)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_we    (host_cnt_we),
        .cnt_wdata (host_cnt_wdata),
        .ofs_we    (host_ofs_we),
        .ofs_wdata (host_ofs_wdata),
        .cnt_o     (cnt_now),
        .ofs_o     (ofs_now)
    );

    vtr_decide #(.PL_W(PL_W)) u_dec (
        .opt_en (cfg_opt_en),
        .vm     (vm_mode),
        .hsec   (host_sec),
        .vsec   (virt_sec),
        .pl     (virt_pl),
        .act    (dec_act),
        .kind   (dec_kind),
        .cause  (dec_cause)
    );

    always_comb begin
        res_d = '0;
        if (rd_req) begin
            res_d.valid = 1'b1;
            res_d.kind  = dec_kind;
            unique case (dec_act)
                ACT_RAW: res_d.data = cnt_now;
                ACT_SUM: res_d.data = cnt_now + ofs_now;
                default: res_d.data = '0;
            endcase
            if (cfg_cause_en && dec_kind == TRAP_INTERCEPT) begin
                res_d.cvld  = 1'b1;
                res_d.cause = dec_cause;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign rd_data     = res_q.data;
    assign rd_valid    = res_q.valid;
    assign trap_kind   = res_q.kind;
    assign cause_valid = res_q.cvld;
    assign cause_code  = res_q.cause;
endmodule

// File: rtl/vtr_read_chk.sv
module vtr_read_chk #(
    parameter int CNT_W = 64,
    parameter int PL_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_opt_en,
    input logic             cfg_cause_en,
    input logic             host_cnt_we,
    input logic [CNT_W-1:0] host_cnt_wdata,
    input logic             rd_req,
    input logic             vm_mode,
    input logic             host_sec,
    input logic             virt_sec,
    input logic [PL_W-1:0]  virt_pl,
    input logic [CNT_W-1:0] rd_data,
    input logic             rd_valid,
    input logic [1:0]       trap_kind,
    input logic             cause_valid,
    input logic [CNT_W-1:0] cnt_now
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !$past(host_cnt_we) |-> cnt_now == $past(cnt_now) + 1'b1);

    p_cnt_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(host_cnt_we) |-> cnt_now == $past(host_cnt_wdata));

    p_raw_outside_vm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && rd_valid && !$past(vm_mode) |-> trap_kind == 2'b00 && rd_data == $past(cnt_now));

    p_fault_needs_pl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && rd_valid && trap_kind == 2'b10 |-> $past(virt_pl) != '0);

    p_undef_row_r9: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && rd_valid && trap_kind == 2'b11 |->
            !$past(cfg_opt_en) && !$past(host_sec) && $past(virt_sec));

    p_cause_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !$past(cfg_cause_en) |-> !cause_valid);

    p_valid_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> rd_valid == $past(rd_req));

    p_trap_no_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && trap_kind != 2'b00 |-> rd_data == '0);
endmodule

bind vtimer_read_unit vtr_read_chk #(.CNT_W(CNT_W), .PL_W(PL_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_opt_en     (cfg_opt_en),
    .cfg_cause_en   (cfg_cause_en),
    .host_cnt_we    (host_cnt_we),
    .host_cnt_wdata (host_cnt_wdata),
    .rd_req         (rd_req),
    .vm_mode        (vm_mode),
    .host_sec       (host_sec),
    .virt_sec       (virt_sec),
    .virt_pl        (virt_pl),
    .rd_data        (rd_data),
    .rd_valid       (rd_valid),
    .trap_kind      (trap_kind),
    .cause_valid    (cause_valid),
    .cnt_now        (cnt_now)
);

// File: tb/vtimer_read_unit_tb.sv
module vtimer_read_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_opt_en = 1'b0, cfg_cause_en = 1'b0;
    logic        host_cnt_we = 1'b0, host_ofs_we = 1'b0;
    logic [63:0] host_cnt_wdata = '0, host_ofs_wdata = '0;
    logic        rd_req = 1'b0, vm_mode = 1'b0, host_sec = 1'b0, virt_sec = 1'b0;
    logic [1:0]  virt_pl = '0;
    logic [63:0] rd_data;
    logic        rd_valid;
    logic [1:0]  trap_kind;
    logic        cause_valid;
    logic [3:0]  cause_code;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [63:0] m_cnt, m_ofs;

    always #4 clk = ~clk;

    vtimer_read_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_opt_en(cfg_opt_en), .cfg_cause_en(cfg_cause_en),
        .host_cnt_we(host_cnt_we), .host_cnt_wdata(host_cnt_wdata),
        .host_ofs_we(host_ofs_we), .host_ofs_wdata(host_ofs_wdata),
        .rd_req(rd_req), .vm_mode(vm_mode), .host_sec(host_sec), .virt_sec(virt_sec),
        .virt_pl(virt_pl), .rd_data(rd_data), .rd_valid(rd_valid), .trap_kind(trap_kind),
        .cause_valid(cause_valid), .cause_code(cause_code)
    );

    // Reference counter and offset, modelled from R1 and R2
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= '0;
            m_ofs <= '0;
        end else begin
            m_cnt <= host_cnt_we ? host_cnt_wdata : m_cnt + 64'd1;
            if (host_ofs_we) m_ofs <= host_ofs_wdata;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic void ref_read(
        input logic opt, input logic cen, input logic vm, input logic hs, input logic vs,
        input logic [1:0] pl, input logic [63:0] c, input logic [63:0] o,
        output logic [63:0] d, output logic [1:0] k, output logic cv, output logic [3:0] cc,
        output string tag);
        d = '0; k = 2'b00; cv = 1'b0; cc = 4'h0;
        if (!vm) begin
            d = c; tag = "R3";
        end else if (!hs && !vs) begin
            d = opt ? c + o : c; tag = opt ? "R5" : "R4";
        end else if (hs && !vs) begin
            k = 2'b01; tag = "R6";
            if (cen) begin cv = 1'b1; cc = 4'h1; end
        end else if (hs && vs) begin
            tag = "R7";
            if (pl != 0) k = 2'b10;
            else begin
                k = 2'b01;
                if (cen) begin cv = 1'b1; cc = 4'h2; end
            end
        end else if (!opt) begin
            k = 2'b11; tag = "R9";
        end else begin
            tag = "R8";
            if (pl != 0) k = 2'b10;
            else d = c + o;
        end
        if (cv) tag = {tag, "/R10"};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a negedge: issues a read (optionally with host loads), checks one cycle later
    task automatic do_read(input logic vm, input logic hs, input logic vs, input logic [1:0] pl,
                           input logic cwe, input logic [63:0] cwd,
                           input logic owe, input logic [63:0] owd);
        logic [63:0] ed; logic [1:0] ek; logic ecv; logic [3:0] ecc; string tag;
        ref_read(cfg_opt_en, cfg_cause_en, vm, hs, vs, pl, m_cnt, m_ofs, ed, ek, ecv, ecc, tag);
        rd_req = 1'b1; vm_mode = vm; host_sec = hs; virt_sec = vs; virt_pl = pl;
        host_cnt_we = cwe; host_cnt_wdata = cwd; host_ofs_we = owe; host_ofs_wdata = owd;
        @(negedge clk);
        rd_req = 1'b0; host_cnt_we = 1'b0; host_ofs_we = 1'b0;
        check({tag, " R11 valid"}, {63'd0, rd_valid}, 64'd1);
        check({tag, " kind"}, {62'd0, trap_kind}, {62'd0, ek});
        check({tag, " data"}, rd_data, ed);
        check({tag, " R10 cause"}, {59'd0, cause_valid, cause_code}, {59'd0, ecv, ecc});
    endtask

    task automatic set_cfg(input logic opt, input logic cen);
        cfg_opt_en = opt; cfg_cause_en = cen;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        check("R11 reset valid", {63'd0, rd_valid}, 64'd0);
        check("R11 reset result", {rd_data[61:0], trap_kind}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: counter is 1 at first negedge after release
        do_read(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, '0, 1'b0, '0);
        check("R1 first count", rd_data, 64'd1);
        // R2: load with same-cycle read sees old value, next read sees loaded, then R1 increment
        do_read(1'b0, 1'b1, 1'b1, 2'd3, 1'b1, 64'd100, 1'b0, '0);
        check("R2 old value on load cycle", rd_data, 64'd2);
        do_read(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, '0, 1'b0, '0);
        check("R2 loaded value", rd_data, 64'd100);
        do_read(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, '0, 1'b0, '0);
        check("R4 raw", rd_data, 64'd101);
        @(negedge clk);
        check("R11 idle valid low", {63'd0, rd_valid}, 64'd0);
        // R1 wrap
        host_cnt_we = 1'b1; host_cnt_wdata = '1;
        @(negedge clk);
        host_cnt_we = 1'b0;
        do_read(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, '0, 1'b0, '0);
        check("R1 all ones", rd_data, 64'hFFFF_FFFF_FFFF_FFFF);
        do_read(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, '0, 1'b0, '0);
        check("R1 wrap to zero", rd_data, 64'd0);
        // R5 sum wrap
        set_cfg(1'b1, 1'b1);
        host_cnt_we = 1'b1; host_cnt_wdata = 64'h20;
        host_ofs_we = 1'b1; host_ofs_wdata = 64'hFFFF_FFFF_FFFF_FFF0;
        @(negedge clk);
        host_cnt_we = 1'b0; host_ofs_we = 1'b0;
        do_read(1'b1, 1'b0, 1'b0, 2'd2, 1'b0, '0, 1'b0, '0);
        check("R5 modulo sum", rd_data, 64'h10);
        // R8 and R7 directed at level boundaries
        do_read(1'b1, 1'b0, 1'b1, 2'd0, 1'b0, '0, 1'b0, '0);
        check("R8 level 0 sum", rd_data, 64'h11);
        do_read(1'b1, 1'b0, 1'b1, 2'd1, 1'b0, '0, 1'b0, '0);
        check("R8 level 1 fault", {62'd0, trap_kind}, 64'd2);
        do_read(1'b1, 1'b1, 1'b1, 2'd0, 1'b0, '0, 1'b0, '0);
        check("R7 level 0 intercept", {62'd0, trap_kind}, 64'd1);
        check("R10 both-secure cause", {60'd0, cause_code}, 64'h2);
        do_read(1'b1, 1'b1, 1'b0, 2'd3, 1'b0, '0, 1'b0, '0);
        check("R6 intercept opt on", {62'd0, trap_kind}, 64'd1);
        set_cfg(1'b0, 1'b0);
        do_read(1'b1, 1'b1, 1'b0, 2'd0, 1'b0, '0, 1'b0, '0);
        check("R6 intercept opt off", {62'd0, trap_kind}, 64'd1);
        check("R10 no cause when disabled", {63'd0, cause_valid}, 64'd0);
        do_read(1'b1, 1'b0, 1'b1, 2'd2, 1'b0, '0, 1'b0, '0);
        check("R9 undefined row", {62'd0, trap_kind}, 64'd3);
        // Constrained random phase
        for (int i = 0; i < 600; i++) begin
            logic vm;
            if (i % 60 == 0) set_cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            vm = ($urandom_range(0, 7) != 0);
            do_read(vm, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    2'($urandom_range(0, 3)),
                    ($urandom_range(0, 9) == 0), {$urandom, $urandom},
                    ($urandom_range(0, 5) == 0), {$urandom, $urandom});
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk);
                check("R11 gap valid low", {63'd0, rd_valid}, 64'd0);
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule